// File: doc/BRIEF.md
# I2C Downstream Channel Select Register

This block is the control side of an I2C bus multiplexer or switch. An upstream I2C controller writes one control byte into the device, and the block turns that byte into connect enables for up to eight downstream buses. The I2C slave front end is not part of the block. It is represented by a one-cycle write strobe with a data byte and a one-cycle read strobe. The pass gates that actually join the bus wires sit outside the block and are driven by the enable outputs.

A build parameter chooses the flavour. In mux flavour a gate bit and a binary channel index pick at most one downstream bus. In switch flavour each low bit of the byte connects its own channel, so any subset can be joined at once. In both flavours the byte 0x00 isolates every downstream bus, and this is also the state after reset. A dedicated reset pin, such as a board-level reset line, clears the register while the clock runs. A read returns the stored byte exactly as it was written.

Top module: `i2c_chan_sel`

## Requirements
- R1: An active-low `rst_n`, which acts asynchronously, or a high `ext_rst_i` sampled on a clock edge sets the control register to 0x00. With the register at 0x00, every bit of `ch_en_o` is 0.
- R2: When `wr_stb_i` is high at a rising edge, `wr_data_i` is loaded into the register at that edge, and `ch_en_o` shows the new decode right after it. Without a strobe the register, and with it `ch_en_o`, does not change.
- R3: When `rd_stb_i` is high at a rising edge, `rd_data_o` takes the register value held before that edge and `rd_valid_o` is 1 for exactly that following cycle. A write in the same cycle affects only later reads. `rd_data_o` holds its value between reads.
- R4: In mux flavour the gate bit is bit 2 when `NUM_CH` is 2 or 4 and bit 3 when `NUM_CH` is 8. The channel index is held in the bits below the gate bit, read as an unsigned binary number.
- R5: In mux flavour with the gate bit set and index k < `NUM_CH`, only `ch_en_o[k]` is 1.
- R6: In mux flavour with the gate bit clear, all of `ch_en_o` is 0 whatever the other bits hold.
- R7: In mux flavour an index of `NUM_CH` or more connects no channel, even with the gate bit set.
- R8: In switch flavour `ch_en_o[n]` equals register bit n for every n < `NUM_CH`, in any combination. Higher bits have no effect.
- R9: Writing 0x00 turns off every channel in both flavours.
- R10: When `ext_rst_i` and `wr_stb_i` are high at the same edge, the reset wins and the register becomes 0x00.
- R11: In mux flavour no more than one bit of `ch_en_o` is ever 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_rst_i | input | 1 | Synchronous reset line for the register, active high |
| wr_stb_i | input | 1 | Byte-write strobe from the I2C slave front end |
| wr_data_i | input | 8 | Byte that is written |
| rd_stb_i | input | 1 | Byte-read strobe from the I2C slave front end |
| rd_data_o | output | 8 | Captured register value |
| rd_valid_o | output | 1 | High for the cycle after a read strobe |
| ch_en_o | output | NUM_CH | Per-channel connect enables |

## Verification
Two pairs of functions can fall in the same cycle: a read with a write, and a write with the reset line. The bench provokes both. A read strobe that shares an edge with a write must return the byte from before that write, and a write that shares an edge with `ext_rst_i` must leave the register at 0x00. Each case is judged against a behavioural model that is updated at every edge. The same stimulus drives an 8-channel mux, an 8-channel switch and a 2-channel mux. This shows the one byte decoded three ways, including the gate-bit position and out-of-range indices.

// File: rtl/i2c_chan_sel_pkg.sv
package i2c_chan_sel_pkg;

    localparam int CTRL_W = 8;
    localparam int MAX_CH = 8;

    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        ctrl_t rd_data;
        logic  rd_valid;
    } sel_state_t;

    // Position of the mux gate bit: bit 2 up to four channels, bit 3 above.
    function automatic int gate_bit_pos(input int nch);
        return (nch > 4) ? 3 : 2;
    endfunction

endpackage

// File: rtl/i2c_chan_sel_reg.sv
module i2c_chan_sel_reg
    import i2c_chan_sel_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ext_rst_i,
    input  logic  wr_stb_i,
    input  ctrl_t wr_data_i,
    input  logic  rd_stb_i,
    output ctrl_t ctrl_o,
    output ctrl_t rd_data_o,
    output logic  rd_valid_o
);

    sel_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // Reads sample the value held before this edge.
        state_d.rd_valid = rd_stb_i;
        if (rd_stb_i) begin
            state_d.rd_data = state_q.ctrl;
        end
        // The reset line takes priority over a write in the same cycle.
        if (ext_rst_i) begin
            state_d.ctrl = '0;
        end else if (wr_stb_i) begin
            state_d.ctrl = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl_o     = state_q.ctrl;
    assign rd_data_o  = state_q.rd_data;
    assign rd_valid_o = state_q.rd_valid;

endmodule

// File: rtl/i2c_chan_sel_dec.sv
module i2c_chan_sel_dec
    import i2c_chan_sel_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter bit IS_SWITCH = 1'b0
) (
    input  ctrl_t             ctrl_i,
    output logic [NUM_CH-1:0] ch_en_o
);

    generate
        if (IS_SWITCH) begin : g_switch
            for (genvar n = 0; n < NUM_CH; n++) begin : g_lane
                assign ch_en_o[n] = ctrl_i[n];
            end
            if (NUM_CH < CTRL_W) begin : g_spare
                logic unused_hi;
                assign unused_hi = ^ctrl_i[CTRL_W-1:NUM_CH];
            end
        end else begin : g_mux
            localparam int GATE  = gate_bit_pos(NUM_CH);
            localparam int IDX_W = GATE;
            logic             gate;
            logic [IDX_W-1:0] idx;
            logic             unused_hi;
            assign gate      = ctrl_i[GATE];
            assign idx       = ctrl_i[IDX_W-1:0];
            assign unused_hi = ^ctrl_i[CTRL_W-1:GATE+1];
            // An index at or above NUM_CH matches no lane and connects nothing.
            for (genvar n = 0; n < NUM_CH; n++) begin : g_lane
                assign ch_en_o[n] = gate && (idx == IDX_W'(n));
            end
        end
    endgenerate

endmodule

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel
    import i2c_chan_sel_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter bit IS_SWITCH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_i,
    input  logic              wr_stb_i,
    input  logic [7:0]        wr_data_i,
    input  logic              rd_stb_i,
    output logic [7:0]        rd_data_o,
    output logic              rd_valid_o,
    output logic [NUM_CH-1:0] ch_en_o
);

    ctrl_t ctrl_q;

    i2c_chan_sel_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_rst_i  (ext_rst_i),
        .wr_stb_i   (wr_stb_i),
        .wr_data_i  (wr_data_i),
        .rd_stb_i   (rd_stb_i),
        .ctrl_o     (ctrl_q),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    i2c_chan_sel_dec #(
        .NUM_CH    (NUM_CH),
        .IS_SWITCH (IS_SWITCH)
    ) u_dec (
        .ctrl_i  (ctrl_q),
        .ch_en_o (ch_en_o)
    );

endmodule

// File: rtl/i2c_chan_sel_chk.sv
module i2c_chan_sel_chk
    import i2c_chan_sel_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter bit IS_SWITCH = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_rst_i,
    input logic              wr_stb_i,
    input logic [7:0]        wr_data_i,
    input logic              rd_stb_i,
    input logic [7:0]        rd_data_o,
    input logic              rd_valid_o,
    input logic [NUM_CH-1:0] ch_en_o,
    input logic [7:0]        ctrl_q
);

    localparam int GATE = gate_bit_pos(NUM_CH);

    p_ext_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_i |=> (ctrl_q == 8'h00) && (ch_en_o == '0));

    p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && !ext_rst_i) |=> ctrl_q == $past(wr_data_i));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb_i && !ext_rst_i) |=> $stable(ctrl_q) && $stable(ch_en_o));

    p_read_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_i |=> rd_valid_o && (rd_data_o == $past(ctrl_q)));

    p_read_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> !rd_valid_o && $stable(rd_data_o));

    p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_SWITCH && !ctrl_q[GATE]) |-> (ch_en_o == '0));

    p_zero_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q == 8'h00) |-> (ch_en_o == '0));

    p_reset_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst_i && wr_stb_i) |=> (ctrl_q == 8'h00));

    p_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        IS_SWITCH || $onehot0(ch_en_o));

endmodule

bind i2c_chan_sel i2c_chan_sel_chk #(
    .NUM_CH    (NUM_CH),
    .IS_SWITCH (IS_SWITCH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_rst_i  (ext_rst_i),
    .wr_stb_i   (wr_stb_i),
    .wr_data_i  (wr_data_i),
    .rd_stb_i   (rd_stb_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .ch_en_o    (ch_en_o),
    .ctrl_q     (ctrl_q)
);

// File: tb/i2c_chan_sel_bench.sv
module i2c_chan_sel_bench;

    localparam int CLK_PERIOD      = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic       clk     = 1'b0;
    logic       rst_n   = 1'b0;
    logic       ext_rst = 1'b0;
    logic       wr_stb  = 1'b0;
    logic       rd_stb  = 1'b0;
    logic [7:0] wr_data = 8'h00;

    logic [7:0] rd_m8, rd_s8, rd_m2;
    logic       rv_m8, rv_s8, rv_m2;
    logic [7:0] en_m8, en_s8;
    logic [1:0] en_m2;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_chan_sel #(.NUM_CH(8), .IS_SWITCH(1'b0)) u_i2c_chan_sel (
        .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst), .wr_stb_i(wr_stb),
        .wr_data_i(wr_data), .rd_stb_i(rd_stb), .rd_data_o(rd_m8),
        .rd_valid_o(rv_m8), .ch_en_o(en_m8));

    i2c_chan_sel #(.NUM_CH(8), .IS_SWITCH(1'b1)) u_i2c_chan_sel_sw (
        .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst), .wr_stb_i(wr_stb),
        .wr_data_i(wr_data), .rd_stb_i(rd_stb), .rd_data_o(rd_s8),
        .rd_valid_o(rv_s8), .ch_en_o(en_s8));

    i2c_chan_sel #(.NUM_CH(2), .IS_SWITCH(1'b0)) u_i2c_chan_sel_m2 (
        .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst), .wr_stb_i(wr_stb),
        .wr_data_i(wr_data), .rd_stb_i(rd_stb), .rd_data_o(rd_m2),
        .rd_valid_o(rv_m2), .ch_en_o(en_m2));

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    finished = 1'b0;

    // Behavioural reference: stored byte plus read capture.
    int m_ctrl = 0;
    int m_rd   = 0;
    int m_rv   = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 0;
            m_rd   = 0;
            m_rv   = 0;
        end else begin
            m_rv = rd_stb ? 1 : 0;
            if (rd_stb) m_rd = m_ctrl;
            if (ext_rst) m_ctrl = 0;
            else if (wr_stb) m_ctrl = int'(wr_data);
        end
    end

    function automatic int expect_en(input int nch, input bit sw, input int v);
        int gate;
        int idx;
        if (sw) return v % (1 << nch);
        gate = (nch == 8) ? 3 : 2;
        if (((v >> gate) & 1) == 0) return 0;
        idx = v % (1 << gate);
        if (idx >= nch) return 0;
        return 1 << idx;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(cur_req, "mux8 enables",   int'(en_m8), expect_en(8, 1'b0, m_ctrl));
        check(cur_req, "switch8 enables", int'(en_s8), expect_en(8, 1'b1, m_ctrl));
        check(cur_req, "mux2 enables",   int'(en_m2), expect_en(2, 1'b0, m_ctrl));
        check(cur_req, "mux8 rd_valid",  int'(rv_m8), m_rv);
        check(cur_req, "mux8 rd_data",   int'(rd_m8), m_rd);
        check(cur_req, "switch8 rd_data", int'(rd_s8), m_rd);
        check(cur_req, "mux2 rd_data",   int'(rd_m2), m_rd);
        check(cur_req, "mux2 rd_valid",  int'(rv_m2), m_rv);
    endtask

    // Compare at the falling edge, then drive the next cycle's inputs.
    task automatic step(input bit w, input logic [7:0] d, input bit r, input bit x);
        @(negedge clk);
        compare_all();
        wr_stb  = w;
        wr_data = d;
        rd_stb  = r;
        ext_rst = x;
    endtask

    task automatic write_then_idle(input logic [7:0] d);
        step(1'b1, d, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) step(1'b0, 8'h00, 1'b0, 1'b0);
        check("R1", "mux8 enables after reset", int'(en_m8), 0);
        check("R1", "rd_valid after reset", int'(rv_m8), 0);
        rst_n = 1'b1;
        step(1'b0, 8'h00, 1'b0, 1'b0);

        // R5/R4: mux8 gate at bit 3, every index
        cur_req = "R5";
        for (int k = 0; k < 8; k++) write_then_idle(8'(8 + k));
        write_then_idle(8'h0D);
        check("R5", "mux8 index 5", int'(en_m8), 32);

        // R4: bit 2 is the gate for 2-channel, an index bit for 8-channel
        cur_req = "R4";
        write_then_idle(8'h04);
        check("R4", "mux2 gate bit 2 idx0", int'(en_m2), 1);
        check("R4", "mux8 bit2 is not gate", int'(en_m8), 0);
        write_then_idle(8'h05);
        check("R4", "mux2 idx1", int'(en_m2), 2);

        // R6: gate clear
        cur_req = "R6";
        write_then_idle(8'hF3);
        check("R6", "mux8 gate clear", int'(en_m8), 0);
        write_then_idle(8'h03);
        check("R6", "mux2 gate clear", int'(en_m2), 0);

        // R7: out-of-range index
        cur_req = "R7";
        write_then_idle(8'h06);
        check("R7", "mux2 index 2", int'(en_m2), 0);
        write_then_idle(8'h07);
        check("R7", "mux2 index 3", int'(en_m2), 0);

        // R8: switch subsets
        cur_req = "R8";
        write_then_idle(8'hA5);
        check("R8", "switch8 0xA5", int'(en_s8), 8'hA5);
        write_then_idle(8'hFF);
        check("R8", "switch8 all", int'(en_s8), 8'hFF);
        check("R8", "mux2 ignores bits above gate", int'(en_m2), 0);

        // R9: 0x00 disconnects all
        cur_req = "R9";
        write_then_idle(8'h00);
        check("R9", "switch8 zero", int'(en_s8), 0);
        check("R9", "mux8 zero", int'(en_m8), 0);

        // R2: data without strobe is ignored
        cur_req = "R2";
        write_then_idle(8'h0A);
        step(1'b0, 8'h0F, 1'b0, 1'b0);
        step(1'b0, 8'h0F, 1'b0, 1'b0);
        check("R2", "mux8 holds without strobe", int'(en_m8), 4);

        // R3: read in the same cycle as a write returns the old byte
        cur_req = "R3";
        write_then_idle(8'h5A);
        step(1'b1, 8'hC3, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        check("R3", "read beside write", int'(rd_m8), 8'h5A);
        check("R3", "rd_valid pulse", int'(rv_m8), 1);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        check("R3", "read after write", int'(rd_s8), 8'hC3);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        check("R3", "rd_valid drops", int'(rv_m8), 0);
        check("R3", "rd_data held", int'(rd_m8), 8'hC3);

        // R10: reset line beats a write in the same cycle
        cur_req = "R10";
        write_then_idle(8'h3C);
        step(1'b1, 8'h0B, 1'b0, 1'b1);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        check("R10", "reset wins over write", int'(en_s8), 0);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        check("R10", "readback after reset", int'(rd_m8), 0);

        // R1: asynchronous reset mid-run
        cur_req = "R1";
        write_then_idle(8'h0C);
        @(negedge clk);
        rst_n = 1'b0;
        step(1'b0, 8'h00, 1'b0, 1'b0);
        check("R1", "async reset clears", int'(en_m8), 0);
        rst_n = 1'b1;

        // R11 and general mix under random traffic
        cur_req = "R11";
        for (int i = 0; i < 400; i++) begin
            step(1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
                 1'($urandom_range(0, 1)), ($urandom_range(0, 15) == 0));
            if ($countones(en_m8) > 1) check("R11", "mux8 one-hot", int'($countones(en_m8)), 1);
        end
        step(1'b0, 8'h00, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule